// File: doc/BRIEF.md
# Address-Filtered Multi-Drop Serial Receiver

This block receives asynchronous serial frames from a line that many nodes share. Each frame has a low start bit, eight data bits sent least significant bit first, one address-marker bit and one high stop bit. A frame whose marker bit is 1 carries a node address. A frame whose marker bit is 0 carries payload. The receiver compares every address frame with its own node address, given on the `local_id` input. It remembers whether it was picked. While it is picked, each payload byte appears on `rx_byte` together with a one-cycle `rx_valid` strobe. While it is not picked, payload traffic is dropped without a trace.

The line is sampled on an oversampling strobe, `os_tick`, which comes from outside the block. One bit lasts `OVS` strobes. A two-stage synchronizer brings the line into the clock domain. The reset is asserted asynchronously and released through its own two-stage synchronizer.

Top module: `mpr_rx_filter`

## Requirements
- R1: A frame is one low start bit, data bits 0 to 7 in that order, the marker bit, then the stop bit. Each bit lasts `OVS` strobes of `os_tick`, and the line rests high between frames.
- R2: After reset, `selected` is 0 and `rx_valid` is 0.
- R3: An address frame (marker 1, stop bit 1) sets `selected` to 1 when its byte equals `local_id`, and clears it otherwise. Nothing else changes `selected`.
- R4: A payload frame (marker 0, stop bit 1) received while `selected` is 1 gives exactly one cycle of `rx_valid`, with `rx_byte` equal to the received byte.
- R5: A payload frame received while `selected` is 0 gives no `rx_valid` and leaves `selected` unchanged.
- R6: An address frame never raises `rx_valid`, whether it matches or not.
- R7: A frame whose stop bit samples 0 is dropped. It gives no `rx_valid` and leaves `selected` unchanged. The receiver then waits for the line to go high before it looks for the next start bit.
- R8: `local_id` is used only when an address frame completes. Changing it while the node is picked leaves following payload frames accepted until the next address frame.
- R9: A low pulse on the line shorter than half a bit is rejected as a false start and produces no frame.
- R10: A frame whose start bit follows the previous stop bit with no idle time is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling strobe; `OVS` strobes per bit |
| rx_in | input | 1 | Serial line, idle high |
| local_id | input | 8 | This node's address |
| rx_byte | output | 8 | Last accepted payload byte |
| rx_valid | output | 1 | One-cycle strobe for an accepted payload byte |
| selected | output | 1 | 1 while this node is picked |

## Verification
The bench targets three cases. The first is a bad stop bit on an address frame while the node is picked: a design that acts on such frames would drop its selection, and the following payload byte would go missing. The second is a change of `local_id` between frames: a design that compares continuously would fall out of selection with no address frame. The third is a short low glitch followed by a good frame: a design with no mid-start check would see a phantom frame and lose bit alignment. The bench also sends frames back to back and a low stop bit that holds the line low. A receiver that does not wait for the line to go high would take the held-low line for a new start bit.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_SHIFT,
    FR_STOP,
    FR_HOLD
  } fr_state_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              mpb;
    logic              stop_ok;
  } frame_t;
endpackage

// File: rtl/mpr_bit_sync.sv
module mpr_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg, stg_n;

  always_comb stg_n = {stg[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= stg_n;
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mpr_frame_rx.sv
module mpr_frame_rx
  import mpr_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   rx,
  output logic   done,
  output frame_t frm
);
  localparam int NB   = DATA_W + 1;
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(NB);
  localparam int HALF = OVS / 2;

  fr_state_t       st, st_n;
  logic [CW-1:0]   cnt, cnt_n;
  logic [BW-1:0]   bitn, bitn_n;
  logic [NB-1:0]   sh, sh_n;
  logic            done_n;
  logic            ok_q, ok_n;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    bitn_n = bitn;
    sh_n   = sh;
    done_n = 1'b0;
    ok_n   = ok_q;
    case (st)
      FR_IDLE: begin
        if (tick && !rx) begin
          st_n  = FR_START;
          cnt_n = '0;
        end
      end
      FR_START: begin
        if (tick) begin
          if (rx) begin
            st_n = FR_IDLE;
          end else if (cnt == CW'(HALF - 1)) begin
            st_n   = FR_SHIFT;
            cnt_n  = '0;
            bitn_n = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
      end
      FR_SHIFT: begin
        if (tick) begin
          if (cnt == CW'(OVS - 1)) begin
            sh_n  = {rx, sh[NB-1:1]};
            cnt_n = '0;
            if (bitn == BW'(NB - 1)) st_n = FR_STOP;
            else                     bitn_n = bitn + 1'b1;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
      end
      FR_STOP: begin
        if (tick) begin
          if (cnt == CW'(OVS - 1)) begin
            done_n = 1'b1;
            ok_n   = rx;
            cnt_n  = '0;
            st_n   = rx ? FR_IDLE : FR_HOLD;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
      end
      FR_HOLD: begin
        if (rx) st_n = FR_IDLE;
      end
      default: st_n = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= FR_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      done <= 1'b0;
      ok_q <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      bitn <= bitn_n;
      sh   <= sh_n;
      done <= done_n;
      ok_q <= ok_n;
    end
  end

  assign frm.data    = sh[DATA_W-1:0];
  assign frm.mpb     = sh[NB-1];
  assign frm.stop_ok = ok_q;
endmodule

// File: rtl/mpr_addr_filter.sv
module mpr_addr_filter
  import mpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  frame_t            frm,
  input  logic [DATA_W-1:0] local_id,
  output logic              vld,
  output logic [DATA_W-1:0] byte_q,
  output logic              sel
);
  logic              good;
  logic              sel_n, sel_en;
  logic              vld_n;
  logic              byte_en;

  always_comb begin
    good    = done && frm.stop_ok;
    sel_en  = good && frm.mpb;
    sel_n   = (frm.data == local_id);
    vld_n   = good && !frm.mpb && sel;
    byte_en = vld_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel    <= 1'b0;
      vld    <= 1'b0;
      byte_q <= '0;
    end else begin
      vld <= vld_n;
      if (sel_en)  sel    <= sel_n;
      if (byte_en) byte_q <= frm.data;
    end
  end
endmodule

// File: rtl/mpr_rx_filter.sv
module mpr_rx_filter
  import mpr_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_in,
  input  logic [DATA_W-1:0] local_id,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              selected
);
  logic   rst_n_s;
  logic   rx_s;
  logic   frm_done;
  frame_t frm_q;

  mpr_bit_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  mpr_bit_sync #(.STAGES(2), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst_n(rst_n_s), .d(rx_in), .q(rx_s)
  );

  mpr_frame_rx #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n_s), .tick(os_tick), .rx(rx_s),
    .done(frm_done), .frm(frm_q)
  );

  mpr_addr_filter u_filt (
    .clk(clk), .rst_n(rst_n_s), .done(frm_done), .frm(frm_q),
    .local_id(local_id), .vld(rx_valid), .byte_q(rx_byte), .sel(selected)
  );
endmodule

// File: rtl/mpr_rx_filter_chk.sv
module mpr_rx_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic fdone,
  input logic fmpb,
  input logic fok,
  input logic rx_valid,
  input logic selected
);
  AST_VALID_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> selected); // R4
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R4
  AST_SEL_ONLY_ON_ID: assert property (@(posedge clk) disable iff (!rst_n)
    !(fdone && fok && fmpb) |=> $stable(selected)); // R3
  AST_SKIP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fdone && !fmpb && !selected) |=> !rx_valid); // R5
  AST_ID_NOT_DELIVERED: assert property (@(posedge clk) disable iff (!rst_n)
    (fdone && fmpb) |=> !rx_valid); // R6
  AST_BAD_STOP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (fdone && !fok) |=> (!rx_valid && $stable(selected))); // R7
endmodule

bind mpr_rx_filter mpr_rx_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fdone(frm_done), .fmpb(frm_q.mpb),
  .fok(frm_q.stop_ok), .rx_valid(rx_valid), .selected(selected)
);

// File: tb/tb_mpr_rx_filter.sv
`timescale 1ns/1ps
module tb_mpr_rx_filter;
  localparam int OVS = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       os_tick;
  logic       rx_in;
  logic [7:0] local_id;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic       selected;

  int compared = 0;
  int mismatched = 0;
  bit chk_en = 0;
  bit win = 0;
  bit msel = 0;
  string tag = "R2";
  logic [7:0] expq[$];

  always #2.5 clk = ~clk;

  mpr_rx_filter #(.OVS(OVS)) dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
    .local_id(local_id), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .selected(selected)
  );

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  // per-cycle comparison against the behavioural model
  always @(negedge clk) begin
    if (chk_en) begin
      if (!win) begin
        compared++;
        if (selected !== msel) begin
          mismatched++;
          $display("FAIL %s selected: actual %0b expected %0b", tag, selected, msel);
        end
      end
      if (rx_valid) begin
        compared++;
        if (!win || expq.size() == 0) begin
          mismatched++;
          $display("FAIL %s rx_valid: actual 1 expected 0 (byte %02h)", tag, rx_byte);
        end else begin
          logic [7:0] e;
          e = expq.pop_front();
          if (rx_byte !== e) begin
            mismatched++;
            $display("FAIL %s rx_byte: actual %02h expected %02h", tag, rx_byte, e);
          end
        end
      end
    end
  end

  // R1 frame: start, d[0..7], marker, stop
  task automatic send_frame(input logic [7:0] d, input logic mpb,
                            input logic stp, input int gap);
    bit nsel;
    rx_in = 1'b0; step(OVS);
    for (int i = 0; i < 8; i++) begin
      rx_in = d[i]; step(OVS);
    end
    rx_in = mpb; step(OVS);
    nsel = msel;
    if (stp) begin
      if (mpb) nsel = (d == local_id);
      else if (msel) expq.push_back(d);
    end
    win = 1; rx_in = stp; step(OVS);
    win = 0;
    compared++;
    if (expq.size() != 0) begin
      mismatched++;
      $display("FAIL %s missing rx_valid: actual none expected %02h", tag, expq[0]);
      expq.delete();
    end
    msel = nsel;
    rx_in = 1'b1;
    if (gap > 0) step(gap);
  endtask

  initial begin
    rst_n = 1'b0; os_tick = 1'b1; rx_in = 1'b1; local_id = 8'h3C;
    step(4);
    rst_n = 1'b1;
    step(4);
    compared += 2; // R2 reset state
    if (selected !== 1'b0) begin
      mismatched++; $display("FAIL R2 selected: actual %0b expected 0", selected);
    end
    if (rx_valid !== 1'b0) begin
      mismatched++; $display("FAIL R2 rx_valid: actual %0b expected 0", rx_valid);
    end
    chk_en = 1;
    step(10);

    tag = "R5"; send_frame(8'h55, 1'b0, 1'b1, 20);
    tag = "R3"; send_frame(8'h22, 1'b1, 1'b1, 20);
    tag = "R5"; send_frame(8'h3C, 1'b0, 1'b1, 20);
    tag = "R3"; send_frame(8'h3C, 1'b1, 1'b1, 20);
    tag = "R4"; send_frame(8'hA5, 1'b0, 1'b1, 20);
    tag = "R1"; send_frame(8'h00, 1'b0, 1'b1, 20);
    tag = "R1"; send_frame(8'hFF, 1'b0, 1'b1, 20);
    tag = "R6"; send_frame(8'h3C, 1'b1, 1'b1, 20);
    tag = "R10"; send_frame(8'h12, 1'b0, 1'b1, 0);
    tag = "R10"; send_frame(8'h34, 1'b0, 1'b1, 0);
    tag = "R10"; send_frame(8'h56, 1'b0, 1'b1, 20);
    tag = "R7"; send_frame(8'h77, 1'b0, 1'b0, 8);
    tag = "R7"; send_frame(8'h78, 1'b0, 1'b1, 20);
    tag = "R7"; send_frame(8'h01, 1'b1, 1'b0, 8);
    tag = "R7"; send_frame(8'h79, 1'b0, 1'b1, 20);
    tag = "R8"; local_id = 8'h81; step(4);
    send_frame(8'h90, 1'b0, 1'b1, 20);
    tag = "R8"; send_frame(8'h3C, 1'b1, 1'b1, 20);
    tag = "R6"; send_frame(8'h81, 1'b1, 1'b1, 20);
    tag = "R9"; rx_in = 1'b0; step(3); rx_in = 1'b1; step(40);
    tag = "R9"; send_frame(8'h5A, 1'b0, 1'b1, 20);
    tag = "R3"; send_frame(8'h80, 1'b1, 1'b1, 20);
    tag = "R5"; send_frame(8'h66, 1'b0, 1'b1, 20);
    tag = "R5"; send_frame(8'h81, 1'b0, 1'b1, 20);
    step(20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule